// File: doc/BRIEF.md
# USB Transceiver UART Pass-Through Mode Controller

This block sequences the alternate operating mode of a USB transceiver in which the parallel link's data lines carry a plain UART instead of packet traffic. A single control-register write arms the mode and at the same time loads the routing and signalling options. The options are: which USB data pin carries transmit, separate transmit and receive enables, a link clock hold bit, and low-voltage signalling. The block then routes the UART transmit line from link data line 0 to one USB pin. It routes the UART receive line from the other USB pin back to link data line 1.

When low-voltage signalling is selected, entering the mode turns the PLL request off and forces the link clock off, whatever the clock hold bit says. The USB-side transmit driver stays off until a regulator-settle interval, counted in controller clock cycles, has run out. The controller clock is a free-running low-frequency reference, so this count keeps running while the PLL is stopped. The stop input ends the session. It turns the transmit driver off combinationally in the same cycle, and the block then waits for the PLL to report lock before it returns to normal link operation.

Top module: `uart_passthru_ctrl`

## Requirements
- R1: After reset, mode_active is 0, both USB output enables are 0, usb_dp_out, usb_dm_out and link_rx_out are 1, and pll_enable and link_clk_en are 1.
- R2: A control write (reg_wr_en high) with bit 0 set enters the mode, and mode_active is 1 from the next clock edge. A write with bit 0 clear leaves mode_active at 0.
- R3: With the direction bit (bit 1) at 0, transmit from link_tx_in drives usb_dm_out with usb_dm_oe high, and link_rx_out follows usb_dp_in. usb_dp_oe is 0 and usb_dp_out is 1.
- R4: With the direction bit at 1, the pins swap roles: transmit drives usb_dp_out with usb_dp_oe high, and link_rx_out follows usb_dm_in. usb_dm_oe is 0 and usb_dm_out is 1.
- R5: The transmit driver is enabled only while the transmit-enable bit (bit 2) is 1. The receive path passes data only while the receive-enable bit (bit 3) is 1, and otherwise link_rx_out holds 1. An undriven pin output is 1.
- R6: With low-voltage select (bit 4) at 0, the transmit driver is on from the first cycle after the entry write, pll_enable stays 1, and link_clk_en equals the clock hold bit (bit 5).
- R7: With low-voltage select at 1, pll_enable and link_clk_en are 0 from the first cycle after entry, whatever the clock hold bit says. The transmit driver turns on exactly SETTLE_CYC cycles after the entry edge.
- R8: While the mode is active, link_stop high drops both USB output enables in the same cycle. At the next edge the block enters the exit phase, in which pll_enable is 1 and the drivers stay off.
- R9: In the exit phase, mode_active stays 1 while pll_lock is 0. It falls at the first clock edge at which pll_lock is sampled 1.
- R10: While mode_active is 1, writes leave the direction and low-voltage bits unchanged. The transmit enable, receive enable and clock hold bits still take effect at the next edge.
- R11: link_stop has no effect while the mode is idle. A stop that arrives on the same edge at which the settle count ends wins, and the transmit driver is never enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running low-frequency reference clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 6 | Control write data: mode, direction, tx enable, rx enable, low voltage, clock hold (bits 0 to 5) |
| link_stop | input | 1 | Stop request from the link controller; ends the session |
| link_tx_in | input | 1 | UART transmit data from link data line 0 |
| link_rx_out | output | 1 | UART receive data to link data line 1 |
| usb_dp_in | input | 1 | Received level on the USB plus pin |
| usb_dm_in | input | 1 | Received level on the USB minus pin |
| usb_dp_out | output | 1 | Drive value for the USB plus pin |
| usb_dp_oe | output | 1 | Output enable for the USB plus pin |
| usb_dm_out | output | 1 | Drive value for the USB minus pin |
| usb_dm_oe | output | 1 | Output enable for the USB minus pin |
| pll_enable | output | 1 | Request to run the PLL |
| pll_lock | input | 1 | PLL lock indication |
| link_clk_en | output | 1 | Request to drive the link output clock |
| mode_active | output | 1 | High from mode entry until exit is complete |

## Verification
Two functions can land on the same edge: the settle counter reaching its terminal count, and a stop request. The bench provokes this by counting cycles after a low-voltage entry and raising link_stop in the cycle just before the terminal edge. It then judges that the block goes to the exit phase with both drivers still off.

A second overlap is a control write arriving while a session runs. The bench writes a swapped direction and low voltage mid-session, together with changed enables. It confirms that the transmit pin does not move and the PLL request stays up, while the enable change shows at the pins.

// File: rtl/upt_pkg.sv
package upt_pkg;

  localparam int CTRL_W    = 6;
  localparam int F_MODE    = 0;
  localparam int F_DIR     = 1;
  localparam int F_TXEN    = 2;
  localparam int F_RXEN    = 3;
  localparam int F_LOWV    = 4;
  localparam int F_CLKHOLD = 5;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_EXIT   = 2'd3
  } upt_state_e;

  typedef struct packed {
    logic clk_hold;
    logic low_volt;
    logic rx_en;
    logic tx_en;
    logic dir_swap;
  } upt_cfg_t;

endpackage

// File: rtl/upt_cfg_reg.sv
module upt_cfg_reg
  import upt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     wr_en,
  input  upt_cfg_t wr_fields,
  input  logic     session_lock,
  output upt_cfg_t cfg_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (wr_en) begin
      cfg_q.tx_en    <= wr_fields.tx_en;
      cfg_q.rx_en    <= wr_fields.rx_en;
      cfg_q.clk_hold <= wr_fields.clk_hold;
      if (!session_lock) begin
        cfg_q.dir_swap <= wr_fields.dir_swap;
        cfg_q.low_volt <= wr_fields.low_volt;
      end
    end
  end

endmodule

// File: rtl/upt_settle_timer.sv
module upt_settle_timer #(
  parameter int SETTLE_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);

  localparam int CW = (SETTLE_CYC > 2) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done = run && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (!done) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/upt_pin_router.sv
module upt_pin_router (
  input  logic dir_swap,
  input  logic tx_drive,
  input  logic rx_pass,
  input  logic link_tx_in,
  input  logic usb_dp_in,
  input  logic usb_dm_in,
  output logic usb_dp_out,
  output logic usb_dp_oe,
  output logic usb_dm_out,
  output logic usb_dm_oe,
  output logic link_rx_out
);

  logic tx_level;
  logic rx_pin;

  assign tx_level = tx_drive ? link_tx_in : 1'b1;
  assign rx_pin   = dir_swap ? usb_dm_in : usb_dp_in;

  always_comb begin
    usb_dp_oe  = tx_drive &&  dir_swap;
    usb_dm_oe  = tx_drive && !dir_swap;
    usb_dp_out = dir_swap ? tx_level : 1'b1;
    usb_dm_out = dir_swap ? 1'b1 : tx_level;
  end

  assign link_rx_out = rx_pass ? rx_pin : 1'b1;

endmodule

// File: rtl/uart_passthru_ctrl.sv
module uart_passthru_ctrl
  import upt_pkg::*;
#(
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [CTRL_W-1:0] reg_wr_data,
  input  logic              link_stop,
  input  logic              link_tx_in,
  output logic              link_rx_out,
  input  logic              usb_dp_in,
  input  logic              usb_dm_in,
  output logic              usb_dp_out,
  output logic              usb_dp_oe,
  output logic              usb_dm_out,
  output logic              usb_dm_oe,
  output logic              pll_enable,
  input  logic              pll_lock,
  output logic              link_clk_en,
  output logic              mode_active
);

  upt_state_e state_q, state_d;
  upt_cfg_t   cfg_q;
  upt_cfg_t   wr_fields;
  logic       settle_done;
  logic       tx_drive;
  logic       rx_pass;
  logic       entry_req;

  assign wr_fields.dir_swap = reg_wr_data[F_DIR];
  assign wr_fields.tx_en    = reg_wr_data[F_TXEN];
  assign wr_fields.rx_en    = reg_wr_data[F_RXEN];
  assign wr_fields.low_volt = reg_wr_data[F_LOWV];
  assign wr_fields.clk_hold = reg_wr_data[F_CLKHOLD];
  assign entry_req          = reg_wr_en && reg_wr_data[F_MODE];

  upt_cfg_reg cfg_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (reg_wr_en),
    .wr_fields    (wr_fields),
    .session_lock (mode_active),
    .cfg_q        (cfg_q)
  );

  upt_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) settle_i (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q == ST_SETTLE),
    .done (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (entry_req) state_d = wr_fields.low_volt ? ST_SETTLE : ST_ACTIVE;
      ST_SETTLE: if (link_stop) state_d = ST_EXIT;
                 else if (settle_done) state_d = ST_ACTIVE;
      ST_ACTIVE: if (link_stop) state_d = ST_EXIT;
      ST_EXIT:   if (pll_lock) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_d;
  end

  assign mode_active = (state_q != ST_IDLE);
  assign tx_drive    = (state_q == ST_ACTIVE) && cfg_q.tx_en && !link_stop;
  assign rx_pass     = ((state_q == ST_ACTIVE) || (state_q == ST_SETTLE)) && cfg_q.rx_en;

  always_comb begin
    unique case (state_q)
      ST_IDLE:   begin pll_enable = 1'b1; link_clk_en = 1'b1; end
      ST_SETTLE: begin pll_enable = 1'b0; link_clk_en = 1'b0; end
      ST_ACTIVE: begin
        pll_enable  = !cfg_q.low_volt;
        link_clk_en = !cfg_q.low_volt && cfg_q.clk_hold;
      end
      default:   begin pll_enable = 1'b1; link_clk_en = 1'b0; end
    endcase
  end

  upt_pin_router router_i (
    .dir_swap    (cfg_q.dir_swap),
    .tx_drive    (tx_drive),
    .rx_pass     (rx_pass),
    .link_tx_in  (link_tx_in),
    .usb_dp_in   (usb_dp_in),
    .usb_dm_in   (usb_dm_in),
    .usb_dp_out  (usb_dp_out),
    .usb_dp_oe   (usb_dp_oe),
    .usb_dm_out  (usb_dm_out),
    .usb_dm_oe   (usb_dm_oe),
    .link_rx_out (link_rx_out)
  );

endmodule

// File: rtl/uart_passthru_ctrl_chk.sv
module uart_passthru_ctrl_chk
  import upt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr_en,
  input logic [CTRL_W-1:0] reg_wr_data,
  input logic              link_stop,
  input logic              usb_dp_oe,
  input logic              usb_dm_oe,
  input logic              pll_enable,
  input logic              pll_lock,
  input logic              link_clk_en,
  input logic              mode_active,
  input logic              dir_q,
  input logic              tx_en_q
);

  AST_ENTRY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
    $rose(mode_active) |-> $past(reg_wr_en && reg_wr_data[F_MODE])); // R2

  AST_SINGLE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    !(usb_dp_oe && usb_dm_oe)); // R3

  AST_TX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (usb_dp_oe || usb_dm_oe) |-> (tx_en_q && mode_active)); // R5

  AST_PLL_OFF_NO_CLOCK: assert property (@(posedge clk) disable iff (rst)
    !pll_enable |-> !link_clk_en); // R7

  AST_STOP_DRIVERS_OFF: assert property (@(posedge clk) disable iff (rst)
    (mode_active && link_stop) |=> (!usb_dp_oe && !usb_dm_oe && pll_enable)); // R8

  AST_EXIT_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    $fell(mode_active) |-> $past(pll_lock)); // R9

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (rst)
    (mode_active && $past(mode_active)) |-> $stable(dir_q)); // R10

endmodule

bind uart_passthru_ctrl uart_passthru_ctrl_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .link_stop   (link_stop),
  .usb_dp_oe   (usb_dp_oe),
  .usb_dm_oe   (usb_dm_oe),
  .pll_enable  (pll_enable),
  .pll_lock    (pll_lock),
  .link_clk_en (link_clk_en),
  .mode_active (mode_active),
  .dir_q       (cfg_q.dir_swap),
  .tx_en_q     (cfg_q.tx_en)
);

// File: tb/uart_passthru_ctrl_tb_top.sv
module uart_passthru_ctrl_tb_top;

  localparam int SETTLE = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr_en = 1'b0;
  logic [5:0] reg_wr_data = '0;
  logic       link_stop = 1'b0;
  logic       link_tx_in = 1'b1;
  logic       usb_dp_in = 1'b1;
  logic       usb_dm_in = 1'b1;
  logic       pll_lock = 1'b1;
  logic       link_rx_out, usb_dp_out, usb_dp_oe, usb_dm_out, usb_dm_oe;
  logic       pll_enable, link_clk_en, mode_active;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  uart_passthru_ctrl #(.SETTLE_CYC(SETTLE)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .link_stop(link_stop), .link_tx_in(link_tx_in), .link_rx_out(link_rx_out),
    .usb_dp_in(usb_dp_in), .usb_dm_in(usb_dm_in),
    .usb_dp_out(usb_dp_out), .usb_dp_oe(usb_dp_oe),
    .usb_dm_out(usb_dm_out), .usb_dm_oe(usb_dm_oe),
    .pll_enable(pll_enable), .pll_lock(pll_lock),
    .link_clk_en(link_clk_en), .mode_active(mode_active)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // {dp_out, dp_oe, dm_out, dm_oe, rx_out}
  function automatic logic [4:0] exp_pins(input logic dir, input logic drv,
                                          input logic rxp, input logic tx,
                                          input logic dp, input logic dm);
    logic lvl;
    logic rx;
    lvl = drv ? tx : 1'b1;
    rx  = rxp ? (dir ? dm : dp) : 1'b1;
    return {dir ? lvl : 1'b1, drv & dir, dir ? 1'b1 : lvl, drv & ~dir, rx};
  endfunction

  function automatic logic [4:0] pins();
    return {usb_dp_out, usb_dp_oe, usb_dm_out, usb_dm_oe, link_rx_out};
  endfunction

  function automatic logic [5:0] ctrl(input logic mode, input logic dir, input logic txe,
                                      input logic rxe, input logic lowv, input logic hold);
    return {hold, lowv, rxe, txe, dir, mode};
  endfunction

  task automatic reg_write(input logic [5:0] d);
    reg_wr_en   = 1'b1;
    reg_wr_data = d;
    @(negedge clk);
    reg_wr_en   = 1'b0;
  endtask

  task automatic finish_exit(input string req);
    // one cycle with stop, then wait for lock
    link_stop = 1'b1;
    @(negedge clk);
    link_stop = 1'b0;
    check(req, {mode_active, pll_enable, usb_dp_oe, usb_dm_oe}, 4'b1100);
    pll_lock = 1'b1;
    @(negedge clk);
    check("R9", mode_active, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", {mode_active, pll_enable, link_clk_en}, 3'b011);
    check("R1", pins(), 5'b10101);

    // R2: write without mode bit
    reg_write(ctrl(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0));
    check("R2", mode_active, 1'b0);

    // R11: stop while idle
    link_stop = 1'b1;
    @(negedge clk);
    link_stop = 1'b0;
    check("R11", {mode_active, usb_dp_oe, usb_dm_oe, pll_enable}, 4'b0001);

    // R3/R5/R6: random normal-voltage sessions
    for (int it = 0; it < 30; it++) begin
      logic dir, txe, rxe, hold;
      dir  = 1'($urandom);
      txe  = (it < 2) ? 1'b1 : 1'($urandom);
      rxe  = (it < 2) ? 1'b1 : 1'($urandom);
      hold = 1'($urandom);
      reg_write(ctrl(1'b1, dir, txe, rxe, 1'b0, hold));
      check("R2", mode_active, 1'b1);
      check("R6", {pll_enable, link_clk_en}, {1'b1, hold});
      for (int k = 0; k < 4; k++) begin
        link_tx_in = 1'($urandom);
        usb_dp_in  = 1'($urandom);
        usb_dm_in  = 1'($urandom);
        #1;
        check(dir ? "R4" : "R3", pins(),
              exp_pins(dir, txe, rxe, link_tx_in, usb_dp_in, usb_dm_in));
        @(negedge clk);
      end
      link_stop = 1'b1;
      #1;
      check("R8", {usb_dp_oe, usb_dm_oe}, 2'b00);
      @(negedge clk);
      link_stop = 1'b0;
      check("R8", {mode_active, usb_dp_oe, usb_dm_oe}, 3'b100);
      @(negedge clk);
      check("R9", mode_active, 1'b0);
    end

    // R10: mid-session writes to direction and voltage select
    link_tx_in = 1'b0;
    reg_write(ctrl(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1));
    check("R6", {usb_dm_oe, usb_dp_oe, usb_dm_out}, 3'b100);
    reg_write(ctrl(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0));
    check("R10", {usb_dm_oe, usb_dp_oe, pll_enable, link_clk_en}, 4'b1010);
    usb_dp_in = 1'b0; usb_dm_in = 1'b1;
    #1;
    check("R10", link_rx_out, 1'b0);
    @(negedge clk);
    reg_write(ctrl(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1));
    check("R10", {usb_dm_oe, usb_dp_oe, usb_dm_out, pll_enable}, 4'b0011);
    finish_exit("R8");

    // R7: low-voltage entry and settle timing
    link_tx_in = 1'b0;
    reg_write(ctrl(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1));
    pll_lock = 1'b0;
    check("R7", {mode_active, pll_enable, link_clk_en, usb_dm_oe}, 4'b1000);
    for (int j = 1; j < SETTLE; j++) begin
      @(negedge clk);
      check("R7", {usb_dm_oe, pll_enable, link_clk_en}, 3'b000);
    end
    @(negedge clk);
    check("R7", {usb_dm_oe, usb_dm_out, pll_enable, link_clk_en}, 4'b1000);
    link_stop = 1'b1;
    #1;
    check("R8", {usb_dp_oe, usb_dm_oe}, 2'b00);
    @(negedge clk);
    link_stop = 1'b0;
    for (int j = 0; j < 3; j++) begin
      check("R9", {mode_active, pll_enable, usb_dm_oe}, 3'b110);
      @(negedge clk);
    end
    pll_lock = 1'b1;
    @(negedge clk);
    check("R9", mode_active, 1'b0);

    // R11: stop coinciding with the settle terminal edge
    reg_write(ctrl(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0));
    pll_lock = 1'b0;
    for (int j = 1; j < SETTLE; j++) @(negedge clk);
    link_stop = 1'b1;
    @(negedge clk);
    link_stop = 1'b0;
    check("R11", {mode_active, pll_enable, usb_dp_oe, usb_dm_oe}, 4'b1100);
    @(negedge clk);
    check("R11", {usb_dp_oe, usb_dm_oe}, 2'b00);
    pll_lock = 1'b1;
    @(negedge clk);
    check("R9", mode_active, 1'b0);

    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule